// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the management registers of external Ethernet PHY devices over the two-wire MDC/MDIO link. The host programs a 32-bit control word and a 16-bit data word. The control word holds the target PHY address, the register address inside that PHY, a clock-range code that fixes the MDC divisor, and the transfer direction. Setting the busy bit starts a transfer. The block then divides the system clock down to MDC and shifts one complete 64-bit management frame on MDIO.

On a write, the frame carries the data word out. On a read, the block releases MDIO at the turnaround and shifts the PHY's 16 answer bits into the data word. Busy falls by itself when the frame is complete. The host polls busy and then reads the result. While busy is high, both host registers are frozen.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After a synchronous active-low reset, the control word and the data word both read 0, `mdc_o` is low and `mdio_oe_o` is low. MDC stays low whenever no frame is in progress.
- R2: The control word is selected by `host_sel`=0. Its fields are: bit 0 busy, bit 1 direction (1 = write), bits 4:2 clock-range code, bits 10:6 register address, bits 15:11 PHY address. Bits 31:16 and bit 5 always read 0.
- R3: The clock-range code sets the MDC period in system clocks: 010 gives 16, 011 gives 26, and 000 gives 42. The reserved codes 001 and 100–111 also give 42. MDC is low for the first half of each bit period and high for the second half.
- R4: A frame is 64 MDC periods, sent MSB first in this order: 32 ones, start 01, opcode (01 write, 10 read), 5 PHY address bits, 5 register address bits, 2 turnaround bits, 16 data bits.
- R5: On a write, `mdio_oe_o` is high for all 64 bits. The turnaround is driven as 10, and the data bits are the data word's contents.
- R6: On a read, `mdio_oe_o` goes low from bit 46 (first turnaround bit) to the end of the frame. `mdio_i` is sampled when MDC rises during bits 48..63. After the frame, the data word holds the 16 sampled bits with the first one as the MSB.
- R7: A control write with bit 0 = 1 starts a frame, and busy reads 1 while it runs. Busy stays high for 64 × divisor + 1 system clocks from the cycle after the write, then clears by itself.
- R8: While busy is 1, host writes to the control word and to the data word have no effect.
- R9: During a frame, MDIO changes only in the cycle in which MDC falls. The only exception is the first bit, which is launched when the frame starts.
- R10: The data word is selected by `host_sel`=1 and can be written and read when idle. Only bits 15:0 are stored, and bits 31:16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Register select: 0 control word, 1 data word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc_o | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable (1 = drive) |
| mdio_i | input | 1 | Management data in |

## Verification
The bench runs frames with every valid clock-range code and with two reserved codes. It measures the busy length in clocks against 64 × divisor + 1. A divisor mapping that is off, or a reserved code that falls through to a faster ratio, shows up as a wrong count. On each MDC rising edge it records MDIO and its enable and compares them with a frame built from the requirements. This catches a swapped opcode, a wrong turnaround pattern, an off-by-one shift, and a read that releases the line one bit late. A PHY model in the bench answers reads with patterns that include all-ones and alternating bits, so a bit-reversed or misaligned capture shows in the data word. Directed tests write both registers in the middle of a frame, where a design that failed to lock them would corrupt the fields or the result. They also read back all-ones control writes to expose reserved bits that were not held at zero.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
// Package: shared field widths, divisor ratios and the command type for the
// MDIO management master. Assumes a 3-bit clock-range code.
package mdio_mgmt_pkg;
    localparam int PHY_AW        = 5;
    localparam int REG_AW        = 5;
    localparam int CR_W          = 3;
    localparam int DIV_W         = 6;
    localparam int DIV_LOW_SYS   = 16;  // 20-35 MHz system clock
    localparam int DIV_MID_SYS   = 26;  // 35-60 MHz system clock
    localparam int DIV_HIGH_SYS  = 42;  // 60-72 MHz system clock, also the safe fallback

    localparam logic [CR_W-1:0] CR_HIGH = 3'b000;
    localparam logic [CR_W-1:0] CR_LOW  = 3'b010;
    localparam logic [CR_W-1:0] CR_MID  = 3'b011;

    typedef struct packed {
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regad;
        logic [CR_W-1:0]   cr;
        logic              wr;
    } mgmt_cmd_t;

    // Maps a clock-range code to the MDC period in system clocks; reserved codes use the slowest ratio.
    function automatic logic [DIV_W-1:0] divisor_for(input logic [CR_W-1:0] cr);
        case (cr)
            CR_LOW:  return DIV_W'(DIV_LOW_SYS);
            CR_MID:  return DIV_W'(DIV_MID_SYS);
            default: return DIV_W'(DIV_HIGH_SYS);
        endcase
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
// MDC generator: while run is high, counts system clocks modulo div and
// produces MDC (low first half, high second half) plus one-cycle strobes
// in the cycles where MDC rises and falls. Assumes div is even, at least 4,
// and stable while run is high. Idle: counter and MDC held at zero.
module mdio_mdc_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_m1;
    logic [DIV_W-1:0] last;

    assign half_m1  = (div >> 1) - DIV_W'(1);
    assign last     = div - DIV_W'(1);
    assign rise_stb = run && (cnt == half_m1);
    assign fall_stb = run && (cnt == last);

    // Divider counter and MDC level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (fall_stb) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + DIV_W'(1);
            if (rise_stb) begin
                mdc <= 1'b1;
            end
        end
    end

    // R3: the counter never passes the programmed period.
    p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < div));
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
// Frame engine: when busy is seen while idle, loads a full management frame
// into a shift register and shifts it out, one bit per MDC period, on the
// fall strobe. Reads release MDIO from the first turnaround bit and shift
// mdio_i in on the rise strobe during the data bits. Pulses done on the fall
// strobe that ends the last bit. Assumes cmd and tx_data are stable while busy.
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  mgmt_cmd_t         cmd,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              running,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int TA_IDX    = PRE_LEN + 4 + PHY_AW + REG_AW;
    localparam int DATA_IDX  = TA_IDX + 2;
    localparam int CNT_W     = $clog2(FRAME_LEN);

    logic [FRAME_LEN-1:0] sh;
    logic [CNT_W-1:0]     bit_cnt;
    logic [CNT_W-1:0]     next_idx;
    logic [FRAME_LEN-1:0] frame;

    assign next_idx = bit_cnt + CNT_W'(1);
    assign mdio_o   = sh[FRAME_LEN-1];
    assign done     = running && fall_stb && (bit_cnt == CNT_W'(FRAME_LEN - 1));

    // Assemble the frame to send from the current command.
    always_comb begin
        frame = {{PRE_LEN{1'b1}}, 2'b01,
                 (cmd.wr ? 2'b01 : 2'b10),
                 cmd.phy, cmd.regad,
                 (cmd.wr ? 2'b10 : 2'b00),
                 (cmd.wr ? tx_data : {DATA_W{1'b0}})};
    end

    // Frame sequencing: load, shift on MDC fall, capture on MDC rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            sh      <= '0;
            bit_cnt <= '0;
            mdio_oe <= 1'b0;
            rx_data <= '0;
        end else if (!running) begin
            if (busy) begin
                running <= 1'b1;
                sh      <= frame;
                bit_cnt <= '0;
                mdio_oe <= 1'b1;
            end
        end else begin
            if (rise_stb && !cmd.wr && (bit_cnt >= CNT_W'(DATA_IDX))) begin
                rx_data <= {rx_data[DATA_W-2:0], mdio_i};
            end
            if (done) begin
                running <= 1'b0;
                sh      <= '0;
                bit_cnt <= '0;
                mdio_oe <= 1'b0;
            end else if (fall_stb) begin
                sh      <= {sh[FRAME_LEN-2:0], 1'b0};
                bit_cnt <= next_idx;
                if (!cmd.wr && (next_idx >= CNT_W'(TA_IDX))) begin
                    mdio_oe <= 1'b0;
                end
            end
        end
    end

    // R5: a write frame drives MDIO for its whole length.
    p_write_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmd.wr) |-> mdio_oe);

    // R6: a read frame has released MDIO from the turnaround on.
    p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cmd.wr && (bit_cnt >= CNT_W'(TA_IDX))) |-> !mdio_oe);

    // R7: a frame only runs while the host sees busy.
    p_run_under_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> busy);
endmodule

// File: rtl/mdio_host_regs.sv
`timescale 1ns/1ps
// Host registers: control word (fields plus busy) and 16-bit data word.
// Writes are accepted only while idle; done clears busy and, for reads,
// loads the received bits into the data word. Read mux is combinational.
module mdio_host_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HOST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output mgmt_cmd_t         cmd,
    output logic [DATA_W-1:0] tx_data
);
    localparam int CR_LSB  = 2;
    localparam int REG_LSB = 6;
    localparam int PHY_LSB = REG_LSB + REG_AW;

    logic unused_wbits;
    assign unused_wbits = ^{host_wdata[HOST_W-1:PHY_LSB+PHY_AW], host_wdata[5]};

    // Register updates: completion first, then idle-only host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cmd     <= '0;
            tx_data <= '0;
        end else if (done) begin
            busy <= 1'b0;
            if (!cmd.wr) begin
                tx_data <= rx_data;
            end
        end else if (host_wr && !busy) begin
            if (!host_sel) begin
                cmd.phy   <= host_wdata[PHY_LSB +: PHY_AW];
                cmd.regad <= host_wdata[REG_LSB +: REG_AW];
                cmd.cr    <= host_wdata[CR_LSB +: CR_W];
                cmd.wr    <= host_wdata[1];
                busy      <= host_wdata[0];
            end else begin
                tx_data <= host_wdata[DATA_W-1:0];
            end
        end
    end

    // Read mux with reserved bits forced to zero.
    always_comb begin
        host_rdata = '0;
        if (!host_sel) begin
            host_rdata[PHY_LSB +: PHY_AW] = cmd.phy;
            host_rdata[REG_LSB +: REG_AW] = cmd.regad;
            host_rdata[CR_LSB +: CR_W]    = cmd.cr;
            host_rdata[1]                 = cmd.wr;
            host_rdata[0]                 = busy;
        end else begin
            host_rdata[DATA_W-1:0] = tx_data;
        end
    end

    // R8: nothing the host holds changes during a frame.
    p_frozen_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cmd) && $stable(tx_data)));

    // R7: completion always ends busy.
    p_done_clears_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
// MDIO management master top: host registers, MDC generator and frame
// engine. The MDC divisor follows the clock-range code held in the
// control word. Assumes an external tri-state buffer built from mdio_o and
// mdio_oe_o, with mdio_i taken from the pad.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32,
    parameter int HOST_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    mgmt_cmd_t         cmd;
    logic              busy;
    logic              done;
    logic              running;
    logic              rise_stb;
    logic              fall_stb;
    logic [DATA_W-1:0] tx_data;
    logic [DATA_W-1:0] rx_data;
    logic [DIV_W-1:0]  div;

    assign div = divisor_for(cmd.cr);

    mdio_host_regs #(.DATA_W(DATA_W), .HOST_W(HOST_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .done(done),
        .rx_data(rx_data), .busy(busy), .cmd(cmd), .tx_data(tx_data)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) mdc_i (
        .clk(clk), .rst_n(rst_n), .run(running), .div(div),
        .mdc(mdc_o), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_engine #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) eng_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .cmd(cmd), .tx_data(tx_data),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .running(running), .mdio_o(mdio_o), .mdio_oe(mdio_oe_o),
        .done(done), .rx_data(rx_data)
    );

    // R1: MDC idles low whenever no frame is running.
    p_mdc_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !mdc_o);

    // R9: inside a frame, MDIO moves only together with an MDC fall.
    p_mdio_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && (mdio_o != $past(mdio_o))) |-> $fell(mdc_o));
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
`timescale 1ns/1ps
// Bench: table-driven frames plus directed reset, reserved-bit and
// write-while-busy tests. A small PHY model answers reads.
module mdio_mgmt_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc_o, mdio_o, mdio_oe_o;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    mdio_mgmt_master dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    // Vector: {cr, wr, phy, reg, data-or-pattern, divisor}
    localparam int NVEC = 6;
    localparam logic [35:0] VEC [NVEC] = '{
        {3'b010, 1'b1, 5'h01, 5'h02, 16'hA5C3, 6'd16},
        {3'b011, 1'b0, 5'h1F, 5'h00, 16'h3C96, 6'd26},
        {3'b000, 1'b1, 5'h00, 5'h1F, 16'h8001, 6'd42},
        {3'b001, 1'b0, 5'h15, 5'h0A, 16'h0F0F, 6'd42},
        {3'b111, 1'b1, 5'h0A, 5'h15, 16'h0000, 6'd42},
        {3'b010, 1'b0, 5'h00, 5'h01, 16'hFFFF, 6'd16}
    };

    // PHY-side monitor and responder state.
    int          rcnt = 0;
    int          fcnt = 0;
    int          rbase = 0;
    int          fbase = 0;
    logic [15:0] rd_pat = '0;
    logic        rec_d  [64];
    logic        rec_oe [64];

    // Record MDIO and its enable on every MDC rise.
    always @(posedge mdc_o) begin
        if ((rcnt - rbase) >= 0 && (rcnt - rbase) < 64) begin
            rec_d[rcnt - rbase]  = mdio_o;
            rec_oe[rcnt - rbase] = mdio_oe_o;
        end
        rcnt = rcnt + 1;
    end

    // Answer read data after each MDC fall.
    always @(negedge mdc_o) begin
        int idx;
        fcnt = fcnt + 1;
        idx  = fcnt - fbase;
        if (idx >= 48 && idx <= 63) mdio_i = rd_pat[63 - idx];
        else mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0; host_sel = 1'b0;
    endtask

    task automatic host_read(input logic sel, output logic [31:0] d);
        @(negedge clk);
        host_sel = sel;
        #1 d = host_rdata;
        host_sel = 1'b0;
    endtask

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0000)};
    endfunction

    task automatic wait_idle(output int cyc);
        cyc = 0;
        host_sel = 1'b0;
        while (host_rdata[0] && cyc < 20000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_frame(input logic [35:0] v);
        logic [2:0]  cr  = v[35:33];
        logic        wr  = v[32];
        logic [4:0]  phy = v[31:27];
        logic [4:0]  rg  = v[26:22];
        logic [15:0] d   = v[21:6];
        int          dv  = int'(v[5:0]);
        logic [63:0] fr;
        logic [31:0] rb;
        int          cyc;
        int          bad = 0;
        if (wr) host_write(1'b1, {16'h0, d});
        rd_pat = d;
        rbase  = rcnt;
        fbase  = fcnt;
        host_write(1'b0, {16'h0, phy, rg, 1'b0, cr, wr, 1'b1});
        wait_idle(cyc);
        // R3, R7: busy length follows the divisor (reserved codes use 42)
        chk(cyc == 64 * dv + 1, "R3/R7 busy cycles", cyc, 64 * dv + 1);
        chk((rcnt - rbase) == 64, "R4 MDC periods per frame", rcnt - rbase, 64);
        fr = exp_frame(wr, phy, rg, d);
        for (int i = 0; i < 64; i++) begin
            logic eo = wr ? 1'b1 : (i < 46);
            if (rec_oe[i] !== eo) bad++;
            if (eo && rec_d[i] !== fr[63 - i]) bad++;
        end
        // R4, R5, R6: serialized bits and output enable per bit
        chk(bad == 0, wr ? "R4/R5 write frame bits" : "R4/R6 read frame bits", bad, 0);
        host_read(1'b1, rb);
        chk(rb == {16'h0, d}, wr ? "R5 data word kept" : "R6 data word captured", rb, {16'h0, d});
        host_read(1'b0, rb);
        chk(rb == {16'h0, phy, rg, 1'b0, cr, wr, 1'b0}, "R2/R7 control after frame",
            rb, {16'h0, phy, rg, 1'b0, cr, wr, 1'b0});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rb;
        int cyc;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        host_read(1'b0, rb);
        chk(rb == 32'h0, "R1 control reset", rb, 32'h0);
        host_read(1'b1, rb);
        chk(rb == 32'h0, "R1 data reset", rb, 32'h0);
        chk({mdc_o, mdio_oe_o} == 2'b00, "R1 mdc/oe idle", {mdc_o, mdio_oe_o}, 2'b00);

        // R2: reserved control bits read zero
        host_write(1'b0, 32'hFFFF_FFFE);
        host_read(1'b0, rb);
        chk(rb == 32'h0000_FFDE, "R2 reserved bits", rb, 32'h0000_FFDE);
        // R10: data word keeps 16 bits
        host_write(1'b1, 32'hFFFF_1234);
        host_read(1'b1, rb);
        chk(rb == 32'h0000_1234, "R10 data word width", rb, 32'h0000_1234);
        chk(mdc_o == 1'b0, "R1 mdc low without start", mdc_o, 0);

        // Table walk
        for (int k = 0; k < NVEC; k++) run_frame(VEC[k]);

        // R8: writes ignored during a write frame
        host_write(1'b1, 32'h0000_1357);
        host_write(1'b0, {16'h0, 5'h03, 5'h04, 1'b0, 3'b010, 1'b1, 1'b1});
        repeat (100) @(negedge clk);
        host_write(1'b0, 32'h0000_FFFC);
        host_write(1'b1, 32'h0000_BEEF);
        host_read(1'b0, rb);
        chk(rb == {16'h0, 5'h03, 5'h04, 1'b0, 3'b010, 1'b1, 1'b1}, "R8 control frozen",
            rb, {16'h0, 5'h03, 5'h04, 1'b0, 3'b010, 1'b1, 1'b1});
        wait_idle(cyc);
        host_read(1'b1, rb);
        chk(rb == 32'h0000_1357, "R8 data write ignored", rb, 32'h0000_1357);

        // R8: data write during a read frame does not override the capture
        rd_pat = 16'h6A59;
        rbase  = rcnt;
        fbase  = fcnt;
        host_write(1'b0, {16'h0, 5'h07, 5'h08, 1'b0, 3'b011, 1'b0, 1'b1});
        repeat (200) @(negedge clk);
        host_write(1'b1, 32'h0000_0000);
        wait_idle(cyc);
        host_read(1'b1, rb);
        chk(rb == 32'h0000_6A59, "R8/R6 capture despite write", rb, 32'h0000_6A59);
        chk({mdc_o, mdio_oe_o} == 2'b00, "R1 idle after frame", {mdc_o, mdio_oe_o}, 2'b00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule